// File: doc/BRIEF.md
# Video M/N Ratio Measurement Unit

This block produces the M term of a stream-to-link clock ratio for a packetised video link, where M/N equals the pixel rate divided by the link symbol rate. It runs in the link symbol clock domain. A toggle flop in the stream (pixel) clock domain flips once per pixel clock. Its state is carried into the link domain through a two-flop synchronizer, and each change is counted as one stream event. Events are counted over a window of link cycles whose length is the programmed N. When N-multiply is set, the window is 2×N, so the measured M reflects twice the input rate. This setting is used for 4:2:0 sampling, combined output pipes and halved pixel-rate modes.

A host programs a seed M, the N value and a control word through a small write port. The intended order is to clear enable, write N and M, then set enable together with the multiply bit. A three-state controller governs the output. In ST_IDLE, auto generation is off and the seed is driven. ST_IDLE goes to ST_PRIME when enable is seen set. ST_PRIME runs the first window while the seed is still driven. ST_PRIME goes to ST_TRACK when that first window ends. ST_TRACK drives the last measured value and refreshes it at the end of every window. ST_PRIME and ST_TRACK both return to ST_IDLE when enable is cleared.

Top module: `vid_ratio_meter`

## Requirements
- R1: After reset, m_val is 0, n_val is the nominal N of 0x8000 and m_upd is low.
- R2: A write with cfg_addr 0 sets the seed M, cfg_addr 1 sets N and cfg_addr 2 sets control (bit 0 enable, bit 1 N-multiply); n_val shows the programmed N and, while not tracking, m_val shows the seed, from the cycle after the write.
- R3: Each reported M equals the number of stream clock cycles that fell within one measurement window of L link cycles, where L is N with N-multiply clear and 2×N with it set (N at least 2, stream clock below half the link clock).
- R4: After enable is written, m_val keeps the seed until the first window ends; the first m_upd is high in the (L+1)-th link cycle after the write edge, and from then m_val is the measured value.
- R5: While enabled, windows run back to back, and m_upd is a single-cycle pulse repeating every L link cycles.
- R6: Clearing enable returns m_val to the seed from the second link cycle after the write, with no m_upd after that; re-enabling starts again from a fresh first window with the seed driven.
- R7: With N-multiply set, n_val still reports the programmed N, not 2×N.
- R8: n_val changes only on a write to cfg_addr 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Link symbol clock |
| lrst_n | input | 1 | Active-low reset, link domain |
| sclk | input | 1 | Stream pixel clock |
| srst_n | input | 1 | Active-low reset, stream domain |
| cfg_we | input | 1 | Register write strobe (link domain) |
| cfg_addr | input | 2 | Register select: 0 seed M, 1 N, 2 control |
| cfg_wdata | input | VAL_W | Write data |
| m_val | output | VAL_W | Current M: seed or measured |
| n_val | output | VAL_W | Programmed N |
| m_upd | output | 1 | One-cycle pulse when a new measured M is latched |

## Verification
A window counter that is one cycle off shifts the strobe timing at once: the first m_upd arrives away from cycle L+1, and every later strobe drifts from the L-cycle spacing. A wrong event count or a window length that ignores N-multiply shows up as a wrong M at the first strobe. A controller stuck in the wrong state shows at the ports within a cycle or two. It appears as a seed that is replaced before the first window ends, or as a seed that is not restored after enable clears, or as strobes that go on while disabled. The scoreboard expects exactly the listed M values at the listed cycle spacing. It flags any strobe that has no queued value.

// File: rtl/vmn_pkg.sv
package vmn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_TRACK = 2'd2
    } win_state_t;

    localparam logic [1:0] ADDR_SEED = 2'd0;
    localparam logic [1:0] ADDR_N    = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/vmn_tick_src.sv
module vmn_tick_src (
    input  logic sclk,
    input  logic srst_n,
    output logic tog
);
    // flips once per stream clock; carries one event per pixel clock
    always_ff @(posedge sclk or negedge srst_n) begin
        if (!srst_n) tog <= 1'b0;
        else         tog <= ~tog;
    end
endmodule

// File: rtl/vmn_tick_sync.sv
module vmn_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_async,
    output logic evt
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], tog_async};
    end

    // last synchronized stage against its delayed copy
    assign evt = chain[CHAIN_W-1] ^ chain[CHAIN_W-2];
endmodule

// File: rtl/vmn_host_regs.sv
module vmn_host_regs
    import vmn_pkg::*;
#(
    parameter int VAL_W = 24,
    parameter int NOM_N = 32'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [VAL_W-1:0] wdata,
    output logic [VAL_W-1:0] seed_m,
    output logic [VAL_W-1:0] prog_n,
    output logic             en,
    output logic             nmul
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_m <= '0;
            prog_n <= VAL_W'(NOM_N);
            en     <= 1'b0;
            nmul   <= 1'b0;
        end else if (we) begin
            unique case (addr)
                ADDR_SEED: seed_m <= wdata;
                ADDR_N:    prog_n <= wdata;
                ADDR_CTRL: begin
                    en   <= wdata[0];
                    nmul <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    AST_N_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == ADDR_N) |=> $stable(prog_n)); // R8
endmodule

// File: rtl/vmn_window_fsm.sv
module vmn_window_fsm
    import vmn_pkg::*;
#(
    parameter int VAL_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             nmul,
    input  logic [VAL_W-1:0] prog_n,
    input  logic [VAL_W-1:0] seed_m,
    input  logic             evt,
    output logic [VAL_W-1:0] m_val,
    output logic             m_upd
);
    localparam int POS_W = VAL_W + 1;

    win_state_t       state, state_nx;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] win_len;
    logic             win_last;
    logic [VAL_W-1:0] cnt;
    logic [VAL_W-1:0] meas;

    assign win_len  = nmul ? {prog_n, 1'b0} : {1'b0, prog_n};
    assign win_last = (pos >= win_len - POS_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (en) state_nx = ST_PRIME;
            ST_PRIME: if (!en) state_nx = ST_IDLE;
                      else if (win_last) state_nx = ST_TRACK;
            ST_TRACK: if (!en) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // window position, event counter and latched measurement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos   <= '0;
            cnt   <= '0;
            meas  <= '0;
            m_upd <= 1'b0;
        end else if (state == ST_IDLE || !en) begin
            pos   <= '0;
            cnt   <= '0;
            m_upd <= 1'b0;
        end else if (win_last) begin
            meas  <= cnt + VAL_W'(evt);
            pos   <= '0;
            cnt   <= '0;
            m_upd <= 1'b1;
        end else begin
            pos   <= pos + POS_W'(1);
            cnt   <= cnt + VAL_W'(evt);
            m_upd <= 1'b0;
        end
    end

    // output selection
    always_comb begin
        unique case (state)
            ST_TRACK: m_val = meas;
            default:  m_val = seed_m;
        endcase
    end

    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        m_upd |=> !m_upd); // R5
    AST_NO_UPD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !m_upd); // R6
    AST_UPD_IN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        m_upd |-> state == ST_TRACK); // R4
    AST_IDLE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == ST_IDLE); // R6
endmodule

// File: rtl/vid_ratio_meter.sv
module vid_ratio_meter #(
    parameter int VAL_W       = 24,
    parameter int NOM_N       = 32'h8000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             lclk,
    input  logic             lrst_n,
    input  logic             sclk,
    input  logic             srst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [VAL_W-1:0] cfg_wdata,
    output logic [VAL_W-1:0] m_val,
    output logic [VAL_W-1:0] n_val,
    output logic             m_upd
);
    logic             s_tog;
    logic             l_evt;
    logic [VAL_W-1:0] seed_m;
    logic             en;
    logic             nmul;

    vmn_tick_src u_src (
        .sclk   (sclk),
        .srst_n (srst_n),
        .tog    (s_tog)
    );

    vmn_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (lclk),
        .rst_n     (lrst_n),
        .tog_async (s_tog),
        .evt       (l_evt)
    );

    vmn_host_regs #(.VAL_W(VAL_W), .NOM_N(NOM_N)) u_regs (
        .clk    (lclk),
        .rst_n  (lrst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .seed_m (seed_m),
        .prog_n (n_val),
        .en     (en),
        .nmul   (nmul)
    );

    vmn_window_fsm #(.VAL_W(VAL_W)) u_fsm (
        .clk    (lclk),
        .rst_n  (lrst_n),
        .en     (en),
        .nmul   (nmul),
        .prog_n (n_val),
        .seed_m (seed_m),
        .evt    (l_evt),
        .m_val  (m_val),
        .m_upd  (m_upd)
    );
endmodule

// File: tb/vid_ratio_meter_tb.sv
module vid_ratio_meter_tb;
    localparam int VAL_W = 24;

    logic             lclk = 1'b0;
    logic             sclk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = '0;
    logic [VAL_W-1:0] cfg_wdata = '0;
    logic [VAL_W-1:0] m_val, n_val;
    logic             m_upd;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int sdiv     = 4;
    int exp_q[$];
    int t_en     = 0;
    int t_last   = 0;
    int exp_len  = 0;
    bit first_pend = 1'b0;
    bit done     = 1'b0;

    vid_ratio_meter #(.VAL_W(VAL_W)) u_dut (
        .lclk      (lclk),
        .lrst_n    (rst_n),
        .sclk      (sclk),
        .srst_n    (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .m_val     (m_val),
        .n_val     (n_val),
        .m_upd     (m_upd)
    );

    always #5 lclk = ~lclk;

    initial begin
        #2;
        forever begin
            #(sdiv * 5);
            sclk = ~sclk;
        end
    end

    always @(posedge lclk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge lclk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = VAL_W'(d);
        @(negedge lclk);
        cfg_we = 1'b0;
    endtask

    // monitor: pops one expected M per strobe and checks its timing
    always @(negedge lclk) begin
        if (rst_n && m_upd) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected strobe", int'(m_val), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(m_val) == e, "R3 measured M", int'(m_val), e);
                if (first_pend) begin
                    check(cyc - t_en == exp_len + 1, "R4 first strobe cycle", cyc - t_en, exp_len + 1);
                    first_pend = 1'b0;
                end else begin
                    check(cyc - t_last == exp_len, "R5 strobe spacing", cyc - t_last, exp_len);
                end
                t_last = cyc;
            end
        end
    end

    // driver: one measurement run
    task automatic run(input int n, input bit mul, input int div, input int seed, input int nwin);
        wr(2'd2, 0);
        sdiv = div;
        repeat (300) @(negedge lclk);
        wr(2'd0, seed);
        wr(2'd1, n);
        check(int'(n_val) == n, "R2 N readback", int'(n_val), n);
        check(int'(m_val) == seed, "R2 seed readback", int'(m_val), seed);
        exp_len = mul ? 2 * n : n;
        for (int i = 0; i < nwin; i++) exp_q.push_back(exp_len / div);
        wr(2'd2, mul ? 3 : 1);
        t_en = cyc;
        first_pend = 1'b1;
        check(int'(m_val) == seed, "R4 seed at enable", int'(m_val), seed);
        repeat (exp_len / 2) @(negedge lclk);
        check(int'(m_val) == seed, "R4 seed mid first window", int'(m_val), seed);
        check(int'(n_val) == n, "R7 N not doubled", int'(n_val), n);
        for (int i = 0; i < (nwin + 1) * exp_len + 20; i++) begin
            if (exp_q.size() == 0) break;
            @(negedge lclk);
        end
        check(exp_q.size() == 0, "R5 all windows reported", exp_q.size(), 0);
        check(int'(m_val) == exp_len / div, "R4 measured value held", int'(m_val), exp_len / div);
        wr(2'd2, 0);
        @(negedge lclk);
        check(int'(m_val) == seed, "R6 seed restored", int'(m_val), seed);
        repeat (2 * exp_len) @(negedge lclk);
        check(!m_upd && int'(m_val) == seed, "R6 quiet after clear", int'(m_val), seed);
    endtask

    initial begin
        repeat (3) @(negedge lclk);
        check(int'(m_val) == 0, "R1 reset M", int'(m_val), 0);
        check(int'(n_val) == 32'h8000, "R1 reset N", int'(n_val), 32'h8000);
        check(!m_upd, "R1 reset strobe", int'(m_upd), 0);
        rst_n = 1'b1;
        run(64, 1'b0, 4, 'h123, 3);
        run(64, 1'b1, 8, 'h55, 2);
        run(64, 1'b0, 8, 'h55, 2);
        run(40, 1'b0, 4, 7, 2);
        run(50, 1'b1, 10, 'h9a, 2);
        wr(2'd1, 100);
        repeat (5) @(negedge lclk);
        check(int'(n_val) == 100, "R8 N holds after write", int'(n_val), 100);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge lclk);
            if (done) break;
        end
        if (!done) check(1'b0, "watchdog", cyc, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule